// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block is the digital control core of a multi-rail switching supply supervisor. Analog comparators outside the block turn rail voltages into flags. This block filters those flags and sequences the supply. It also decides when the supply is healthy and when it must be forced off. Every comparator flag and the power-good input pass through a short noise filter. The active-low on/off request passes through a much longer debounce.

Over-voltage on any of the three monitored rails (5 V, 3.3 V, 12 V) sets a protection latch at any time. Under-voltage is watched only on the 5 V and 3.3 V rails, and only after a blanking period that follows turn-on. This hides start-up and short-circuit transients. A set latch drops the power-good output and raises the shutdown output. The latch stays set until a debounced off request is seen.

Power-good rises only after a long qualification period. It falls at once when that qualification is lost. All delays count a clock-enable tick, so the time base is set by whoever drives the tick.

Top module: `psu_supervisor_seq`

## Requirements
- R1: A change on any comparator flag or on the power-good input takes effect only after it has persisted for GLITCH_TICKS ticks. A pulse shorter than that has no effect on either output.
- R2: The on/off request (`onOffReqN`, 0 = on, 1 = off) takes effect only after it has been stable for DEBOUNCE_TICKS ticks. A shorter off pulse neither turns the supply off nor clears the latch.
- R3: A filtered over-voltage flag sets the protection latch whether the supply is on or off. The flag bits of `ovFlags` are: bit 0 for 5 V, bit 1 for 3.3 V, bit 2 for 12 V.
- R4: A filtered under-voltage flag sets the latch only once the supply has been on (debounced) for BLANK_TICKS ticks. The flag bits of `uvFlags` are: bit 0 for 5 V, bit 1 for 3.3 V. Before that point the flag is ignored.
- R5: While the latch is set, `faultOff` is 1 and `pwrGood` is 0. Clearing the fault flags does not clear the latch. Only a debounced on-to-off transition of the request clears it.
- R6: While the debounced request is off, `faultOff` is 1.
- R7: `pwrGood` rises after the qualification has held for PG_TICKS ticks. The qualification is: filtered power-good input high, no filtered under-voltage flag, supply on, and latch clear. `pwrGood` falls in the same cycle the qualification is lost, and the count then restarts from zero.
- R8: Filters and delay counters advance only in cycles where `tick` is 1.
- R9: A synchronous reset gives `pwrGood` = 0, `faultOff` = 1, the latch clear, the request treated as off, and all counters zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base enable for all filters and counters |
| ovFlags | input | 3 | Over-voltage flags: bit0 5 V, bit1 3.3 V, bit2 12 V |
| uvFlags | input | 2 | Under-voltage flags: bit0 5 V, bit1 3.3 V |
| pgIn | input | 1 | Power-good input, 1 = good |
| onOffReqN | input | 1 | On/off request, 0 = on, 1 = off |
| pwrGood | output | 1 | Power-good output, active high |
| faultOff | output | 1 | Shutdown output, 1 = supply off |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that `tick` is a plain enable and not a value that has to follow a fixed period. The bench drives all inputs at the falling edge and holds each pattern for a whole number of cycles, so every filter sees clean, stable levels. Most runs keep `tick` high. One directed phase holds it low, so the frozen-counter check is exercised with the same kind of input.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;
  localparam int NUM_OV = 3;
  localparam int NUM_UV = 2;

  typedef struct packed {
    logic [NUM_OV-1:0] ov;
    logic [NUM_UV-1:0] uv;
    logic              pgOk;
    logic              offReq;
  } supFlags_t;

  typedef struct packed {
    logic blankRun;
    logic pgRun;
  } supStrobe_t;
endpackage

// File: rtl/psu_deglitch.sv
module psu_deglitch #(
  parameter int COUNT   = 73,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(COUNT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= RST_VAL;
      cnt  <= '0;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(COUNT - 1)) begin
        dout <= din;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: without a tick the filtered value cannot move
  assert_filter_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dout));
endmodule

// File: rtl/psu_hold_timer.sv
module psu_hold_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick && cnt != CW'(LIMIT))
      cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(LIMIT));

  // R8: no tick means the count holds unless the run condition drops
  assert_timer_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick && run) |=> (cnt == $past(cnt) || !run));
endmodule

// File: rtl/psu_sup_datapath.sv
module psu_sup_datapath
  import psu_sup_pkg::*;
#(
  parameter int GLITCH_TICKS   = 73,
  parameter int DEBOUNCE_TICKS = 38000,
  parameter int BLANK_TICKS    = 75000,
  parameter int PG_TICKS       = 300000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NUM_OV-1:0] ovRaw,
  input  logic [NUM_UV-1:0] uvRaw,
  input  logic              pgRaw,
  input  logic              reqRawN,
  input  supStrobe_t        strobe,
  output supFlags_t         flags,
  output logic              blankDone,
  output logic              pgDone
);
  for (genvar i = 0; i < NUM_OV; i++) begin : g_ov
    psu_deglitch #(.COUNT(GLITCH_TICKS), .RST_VAL(1'b0)) u_flt (
      .clk(clk), .rst(rst), .tick(tick), .din(ovRaw[i]), .dout(flags.ov[i]));
  end

  for (genvar j = 0; j < NUM_UV; j++) begin : g_uv
    psu_deglitch #(.COUNT(GLITCH_TICKS), .RST_VAL(1'b0)) u_flt (
      .clk(clk), .rst(rst), .tick(tick), .din(uvRaw[j]), .dout(flags.uv[j]));
  end

  psu_deglitch #(.COUNT(GLITCH_TICKS), .RST_VAL(1'b0)) u_pgFlt (
    .clk(clk), .rst(rst), .tick(tick), .din(pgRaw), .dout(flags.pgOk));

  psu_deglitch #(.COUNT(DEBOUNCE_TICKS), .RST_VAL(1'b1)) u_reqDeb (
    .clk(clk), .rst(rst), .tick(tick), .din(reqRawN), .dout(flags.offReq));

  psu_hold_timer #(.LIMIT(BLANK_TICKS)) u_blank (
    .clk(clk), .rst(rst), .tick(tick), .run(strobe.blankRun), .done(blankDone));

  psu_hold_timer #(.LIMIT(PG_TICKS)) u_pgDelay (
    .clk(clk), .rst(rst), .tick(tick), .run(strobe.pgRun), .done(pgDone));
endmodule

// File: rtl/psu_sup_control.sv
module psu_sup_control
  import psu_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  supFlags_t  flags,
  input  logic       blankDone,
  input  logic       pgDone,
  output supStrobe_t strobe,
  output logic       pwrGood,
  output logic       faultOff
);
  logic offPrev;
  logic protLatch;
  logic offRise;
  logic ovAny;
  logic uvAny;
  logic supplyOn;

  assign ovAny    = |flags.ov;
  assign uvAny    = |flags.uv;
  assign supplyOn = !flags.offReq;
  assign offRise  = flags.offReq && !offPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      offPrev   <= 1'b1;
      protLatch <= 1'b0;
    end else begin
      offPrev <= flags.offReq;
      if (offRise)
        protLatch <= 1'b0;
      else if (ovAny || (blankDone && uvAny))
        protLatch <= 1'b1;
    end
  end

  always_comb begin
    strobe.blankRun = supplyOn;
    strobe.pgRun    = supplyOn && flags.pgOk && !uvAny && !protLatch;
  end

  assign pwrGood  = pgDone;
  assign faultOff = protLatch || flags.offReq;

  // R5: a set latch shuts the supply and drops power-good
  assert_latch_forces_R5: assert property (@(posedge clk) disable iff (rst)
    protLatch |-> (faultOff && !pwrGood));
  // R5: only an off transition releases the latch
  assert_latch_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (protLatch && !flags.offReq) |=> protLatch);
  // R6: off request keeps the supply down
  assert_off_forces_R6: assert property (@(posedge clk) disable iff (rst)
    flags.offReq |-> faultOff);
  // R3/R4: the latch only sets on over-voltage or unblanked under-voltage
  assert_latch_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(protLatch) |-> $past(ovAny || (blankDone && uvAny)));
  // R7: power-good never stands with its qualification missing
  assert_pg_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    pwrGood |-> (flags.pgOk && !uvAny && supplyOn));
endmodule

// File: rtl/psu_supervisor_seq.sv
module psu_supervisor_seq
  import psu_sup_pkg::*;
#(
  parameter int GLITCH_TICKS   = 73,
  parameter int DEBOUNCE_TICKS = 38000,
  parameter int BLANK_TICKS    = 75000,
  parameter int PG_TICKS       = 300000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [2:0] ovFlags,
  input  logic [1:0] uvFlags,
  input  logic       pgIn,
  input  logic       onOffReqN,
  output logic       pwrGood,
  output logic       faultOff
);
  supFlags_t  flags;
  supStrobe_t strobe;
  logic       blankDone;
  logic       pgDone;

  psu_sup_datapath #(
    .GLITCH_TICKS(GLITCH_TICKS), .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .BLANK_TICKS(BLANK_TICKS), .PG_TICKS(PG_TICKS)
  ) u_dp (
    .clk(clk), .rst(rst), .tick(tick),
    .ovRaw(ovFlags), .uvRaw(uvFlags), .pgRaw(pgIn), .reqRawN(onOffReqN),
    .strobe(strobe), .flags(flags), .blankDone(blankDone), .pgDone(pgDone));

  psu_sup_control u_ctl (
    .clk(clk), .rst(rst), .flags(flags), .blankDone(blankDone),
    .pgDone(pgDone), .strobe(strobe), .pwrGood(pwrGood), .faultOff(faultOff));
endmodule

// File: tb/tb_psu_supervisor_seq.sv
`timescale 1ns/1ps
module tb_psu_supervisor_seq;
  localparam int GT = 3, DT = 5, BT = 8, PT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [2:0] ovFlags = '0;
  logic [1:0] uvFlags = 2'b11;
  logic pgIn = 1'b0;
  logic onOffReqN = 1'b1;
  logic pwrGood, faultOff;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  psu_supervisor_seq #(.GLITCH_TICKS(GT), .DEBOUNCE_TICKS(DT),
                       .BLANK_TICKS(BT), .PG_TICKS(PT)) dut (
    .clk(clk), .rst(rst), .tick(tick), .ovFlags(ovFlags), .uvFlags(uvFlags),
    .pgIn(pgIn), .onOffReqN(onOffReqN), .pwrGood(pwrGood), .faultOff(faultOff));

  typedef struct packed {
    logic [2:0] ov;
    logic [1:0] uv;
    logic       pg;
    logic       reqN;
    logic [7:0] hold;
    logic       expPg;
    logic       expFault;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 2'b11, 1'b0, 1'b1, 8'd10, 1'b0, 1'b1, 4'd6}, // R6 off
    '{3'b000, 2'b11, 1'b0, 1'b0, 8'd3,  1'b0, 1'b1, 4'd2}, // R2 not yet debounced
    '{3'b000, 2'b11, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 4'd4}, // R4 UV blanked at turn-on
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd20, 1'b1, 1'b0, 4'd7}, // R7 power good
    '{3'b000, 2'b00, 1'b0, 1'b0, 8'd2,  1'b1, 1'b0, 4'd1}, // R1 short pg glitch
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd5,  1'b1, 1'b0, 4'd1},
    '{3'b000, 2'b00, 1'b0, 1'b0, 8'd4,  1'b0, 1'b0, 4'd7}, // R7 fast drop
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0, 4'd7}, // R7 restart
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd8,  1'b1, 1'b0, 4'd7},
    '{3'b000, 2'b01, 1'b1, 1'b0, 8'd2,  1'b1, 1'b0, 4'd1}, // R1 short UV
    '{3'b000, 2'b01, 1'b1, 1'b0, 8'd5,  1'b0, 1'b1, 4'd4}, // R4 UV latches
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd10, 1'b0, 1'b1, 4'd5}, // R5 latch holds
    '{3'b000, 2'b00, 1'b1, 1'b1, 8'd10, 1'b0, 1'b1, 4'd6}, // R6 off clears latch
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd10, 1'b0, 1'b0, 4'd5}, // R5 cleared
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd10, 1'b1, 1'b0, 4'd7},
    '{3'b010, 2'b00, 1'b1, 1'b0, 8'd2,  1'b1, 1'b0, 4'd1}, // R1 short OV
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd1,  1'b1, 1'b0, 4'd1},
    '{3'b100, 2'b00, 1'b1, 1'b0, 8'd5,  1'b0, 1'b1, 4'd3}, // R3 12 V OV
    '{3'b000, 2'b00, 1'b1, 1'b1, 8'd3,  1'b0, 1'b1, 4'd2}, // R2 short off pulse
    '{3'b000, 2'b00, 1'b1, 1'b0, 8'd10, 1'b0, 1'b1, 4'd2}, // R2 latch not cleared
    '{3'b001, 2'b00, 1'b1, 1'b0, 8'd5,  1'b0, 1'b1, 4'd3}  // R3 5 V OV
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    hold(3);
    check("R9 reset pwrGood", pwrGood, 1'b0);
    check("R9 reset faultOff", faultOff, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ovFlags = VECS[i].ov; uvFlags = VECS[i].uv;
      pgIn = VECS[i].pg; onOffReqN = VECS[i].reqN;
      hold(int'(VECS[i].hold));
      check($sformatf("R%0d vec%0d pwrGood", VECS[i].req, i), pwrGood, VECS[i].expPg);
      check($sformatf("R%0d vec%0d faultOff", VECS[i].req, i), faultOff, VECS[i].expFault);
    end

    // R9: reset in a latched, on state
    ovFlags = '0; rst = 1'b1;
    hold(2);
    check("R9 mid reset pwrGood", pwrGood, 1'b0);
    check("R9 mid reset faultOff", faultOff, 1'b1);
    rst = 1'b0;
    hold(10);
    check("R9 latch cleared by reset", faultOff, 1'b0);

    // R4: UV present through turn-on is blanked, then latches
    onOffReqN = 1'b1; hold(10);
    uvFlags = 2'b11; hold(5);
    onOffReqN = 1'b0; hold(9);
    check("R4 UV blanked", faultOff, 1'b0);
    hold(10);
    check("R4 UV after blank", faultOff, 1'b1);
    check("R4 UV pwrGood", pwrGood, 1'b0);

    // R8: no tick, no progress
    uvFlags = 2'b00; onOffReqN = 1'b1; hold(10);
    onOffReqN = 1'b0; hold(20);
    check("R8 on before tick test", faultOff, 1'b0);
    tick = 1'b0; ovFlags = 3'b001; hold(10);
    check("R8 OV frozen without tick", faultOff, 1'b0);
    tick = 1'b1; hold(5);
    check("R8 OV accepted with tick", faultOff, 1'b1);

    finish_run();
  end
endmodule